// File: doc/BRIEF.md
# Dual-Bit SPI Transmit Master

This block is a transmit-driven SPI master that shifts 8-bit words out to one of three logical targets. A byte arrives on a valid/ready handshake along with per-byte flags. The flags choose single-bit or two-bit mode, name the target, say whether this byte ends the command, and say whether the received byte should be returned. In single-bit mode the byte goes out most significant bit first, one bit per serial clock. In two-bit mode a spare select line (`sel_aux`) carries a second data bit, so one byte takes four serial clocks.

The target is encoded on two physical select lines. Index 2 uses one pattern, and every other index shares the other pattern. The select stays asserted between bytes of one command. It is released, with both lines high, after the byte flagged as last. The serial clock half-period is a parameter counted in system clocks. In single-bit mode, the bits sampled from `sdi` on each rising serial clock edge are returned as one byte after each transmitted byte.

Top module: `dspi_tx_master`

## Requirements
- R1: `in_ready` is high only while no byte is being shifted. A byte is accepted in a cycle with `in_valid` and `in_ready` both high. `in_ready` is then low from the next cycle until that byte has finished.
- R2: In single-bit mode (`in_dual`=0) a byte produces exactly 8 rising `sclk` edges. `sdo` carries bit 7 at the first edge, then bit 6, and so on down to bit 0.
- R3: In two-bit mode (`in_dual`=1) a byte produces exactly 4 rising `sclk` edges. At edge k (k=0..3), `sdo` carries bit 7-2k and `sel_aux` carries bit 6-2k, so the pairs go out in the order 7:6, 5:4, 3:2, 1:0.
- R4: Every bit period holds `sclk` low for HALF_PERIOD system clocks, with the data lines already set, then high for HALF_PERIOD clocks. Consecutive rising edges are therefore 2*HALF_PERIOD clocks apart, and `sdo` and `sel_aux` do not change while `sclk` is high.
- R5: Target index 2 is selected with `sel_a`=1 and `sel_b`=0. Any other index (0, 1 or 3) is selected with `sel_a`=0 and `sel_b`=1. The two lines are never low together.
- R6: When a byte flagged `in_last` finishes, `sel_a` and `sel_b` are both high by the cycle `in_ready` returns. After a byte without the flag, the selection stays asserted.
- R7: `sel_aux` is high whenever no two-bit-mode byte is being shifted.
- R8: For a single-bit byte with `in_rx`=1, `rx_valid` pulses for one cycle in the cycle `in_ready` returns. `rx_data` then holds the 8 `sdi` samples taken at the rising `sclk` edges, the first sample in bit 7.
- R9: In two-bit mode `in_rx` has no effect: `rx_valid` stays low for that byte.
- R10: `sclk` is low whenever the block is idle. After reset, `in_ready`=1, `sclk`=0, `sel_a`=`sel_b`=`sel_aux`=1 and `rx_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Byte to transmit |
| in_dual | input | 1 | 1 selects two-bit mode for this byte |
| in_dev | input | 2 | Logical target index |
| in_last | input | 1 | Release the select after this byte |
| in_rx | input | 1 | Return the received byte (single-bit mode) |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out, high bit of a pair in two-bit mode |
| sdi | input | 1 | Serial data in |
| sel_a | output | 1 | Select line, low for targets other than 2 |
| sel_b | output | 1 | Select line, low for target 2 |
| sel_aux | output | 1 | Spare select, low bit of a pair in two-bit mode |
| rx_valid | output | 1 | Received byte available (one-cycle pulse) |
| rx_data | output | 8 | Received byte |

## Verification
The bench builds the block with HALF_PERIOD=2. This keeps each byte near 35 system clocks, so every one of the 256 byte values can be sent in both modes to all four target indices. The commands are four bytes long, so both the held select between bytes and the release after the last byte come up hundreds of times. A short half-period also makes an off-by-one in the phase counter show up directly as a wrong spacing between rising edges.

// File: rtl/dspi_pkg.sv
package dspi_pkg;
  localparam int unsigned WORD_W = 8;
  localparam int unsigned DEV_W  = 2;
  localparam int unsigned BEAT_W = $clog2(WORD_W);
  localparam logic [DEV_W-1:0] ALT_DEV = DEV_W'(2);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} phase_e;

  // index of the final beat of a byte: 8 beats single, 4 beats dual
  function automatic logic [BEAT_W-1:0] final_beat(input logic dual);
    return dual ? BEAT_W'(WORD_W/2 - 1) : BEAT_W'(WORD_W - 1);
  endfunction

  // select pattern {sel_a, sel_b} for an asserted target
  function automatic logic [1:0] select_pattern(input logic [DEV_W-1:0] dev);
    return (dev == ALT_DEV) ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/dspi_phase_timer.sv
module dspi_phase_timer #(
  parameter int unsigned HALF_PERIOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int unsigned CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt;

  assign phase_end = run && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dspi_shift_core.sv
module dspi_shift_core #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              advance,
  input  logic              two_bit,
  input  logic              sample,
  input  logic              sdi,
  output logic              tx_hi,
  output logic              tx_lo,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_sh;

  assign tx_hi = tx_sh[WORD_W-1];
  assign tx_lo = tx_sh[WORD_W-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tx_sh <= '0;
    else if (load)    tx_sh <= load_word;
    else if (advance) tx_sh <= two_bit ? {tx_sh[WORD_W-3:0], 2'b00}
                                       : {tx_sh[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rx_word <= '0;
    else if (sample) rx_word <= {rx_word[WORD_W-2:0], sdi};
  end
endmodule

// File: rtl/dspi_tx_master.sv
module dspi_tx_master
  import dspi_pkg::*;
#(
  parameter int unsigned HALF_PERIOD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_dual,
  input  logic [DEV_W-1:0]  in_dev,
  input  logic              in_last,
  input  logic              in_rx,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic              sel_a,
  output logic              sel_b,
  output logic              sel_aux,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  phase_e            phase;
  logic              dual_q, last_q, rx_q;
  logic [BEAT_W-1:0] beat;
  logic              phase_end;
  logic              tx_hi, tx_lo;
  logic [WORD_W-1:0] rx_word;

  // named internal events
  logic accept, bit_rise, bit_fall, byte_done, active;
  assign active    = (phase != ST_IDLE);
  assign accept    = in_valid && (phase == ST_IDLE);
  assign bit_rise  = (phase == ST_LOW)  && phase_end;
  assign bit_fall  = (phase == ST_HIGH) && phase_end;
  assign byte_done = bit_fall && (beat == final_beat(dual_q));

  dspi_phase_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(active), .phase_end(phase_end)
  );

  dspi_shift_core #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_word(in_data),
    .advance(bit_fall && !byte_done), .two_bit(dual_q),
    .sample(bit_rise), .sdi(sdi),
    .tx_hi(tx_hi), .tx_lo(tx_lo), .rx_word(rx_word)
  );

  assign in_ready = (phase == ST_IDLE);
  assign sdo      = active && tx_hi;
  assign sel_aux  = (active && dual_q) ? tx_lo : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= ST_IDLE;
      dual_q   <= 1'b0;
      last_q   <= 1'b0;
      rx_q     <= 1'b0;
      beat     <= '0;
      sclk     <= 1'b0;
      sel_a    <= 1'b1;
      sel_b    <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      unique case (phase)
        ST_IDLE: if (accept) begin
          phase          <= ST_LOW;
          dual_q         <= in_dual;
          last_q         <= in_last;
          rx_q           <= in_rx;
          beat           <= '0;
          sclk           <= 1'b0;
          {sel_a, sel_b} <= select_pattern(in_dev);
        end
        ST_LOW: if (bit_rise) begin
          sclk  <= 1'b1;
          phase <= ST_HIGH;
        end
        ST_HIGH: if (bit_fall) begin
          sclk <= 1'b0;
          if (byte_done) begin
            phase    <= ST_IDLE;
            rx_valid <= rx_q && !dual_q;
            rx_data  <= rx_word;
            if (last_q) {sel_a, sel_b} <= 2'b11;
          end else begin
            beat  <= beat + 1'b1;
            phase <= ST_LOW;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dspi_tx_master_chk.sv
module dspi_tx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic sdo,
  input logic sel_a,
  input logic sel_b,
  input logic sel_aux,
  input logic rx_valid,
  input logic byte_done,
  input logic dual_q,
  input logic active
);
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_done_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> in_ready);

  p_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> ($stable(sdo) && $stable(sel_aux)));

  p_never_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_a && !sel_b));

  p_clock_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (sel_a != sel_b));

  p_aux_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(active && dual_q) |-> sel_aux);

  p_rx_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> in_ready);

  p_rx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_idle_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !sclk);
endmodule

bind dspi_tx_master dspi_tx_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .sclk(sclk), .sdo(sdo), .sel_a(sel_a), .sel_b(sel_b), .sel_aux(sel_aux),
  .rx_valid(rx_valid), .byte_done(byte_done), .dual_q(dual_q), .active(active)
);

// File: tb/test_dspi_tx_master.sv
module test_dspi_tx_master;
  localparam int HALF = 2;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_dual = 1'b0;
  logic [1:0] in_dev = '0;
  logic       in_last = 1'b0;
  logic       in_rx = 1'b0;
  logic       sclk, sdo, sel_a, sel_b, sel_aux, rx_valid;
  logic       sdi = 1'b0;
  logic [7:0] rx_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dspi_tx_master #(.HALF_PERIOD(HALF)) i_dspi_tx_master (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_dual(in_dual), .in_dev(in_dev), .in_last(in_last),
    .in_rx(in_rx), .sclk(sclk), .sdo(sdo), .sdi(sdi), .sel_a(sel_a),
    .sel_b(sel_b), .sel_aux(sel_aux), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input bit dual, input logic [1:0] dev,
                      input bit last, input bit rxen, input logic [7:0] slave);
    logic [7:0] cap = '0;
    logic [1:0] sel_exp;
    int rises = 0, gap = 0, sidx = 7, bad_gap = 0, bad_sel = 0, bad_hold = 0;
    bit first = 1'b1;
    logic prev_s = 1'b0, prev_d = 1'b0, prev_x = 1'b1;
    sel_exp = (dev == 2'd2) ? 2'b10 : 2'b01;   // R5 encoding {sel_a, sel_b}
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = tx; in_dual = dual; in_dev = dev;
    in_last = last; in_rx = rxen; sdi = slave[7];
    @(negedge clk);
    in_valid = 1'b0;
    while (!in_ready) begin
      if (sclk && !prev_s) begin
        if (dual) cap = {cap[5:0], sdo, sel_aux};
        else      cap = {cap[6:0], sdo};
        rises++;
        if ({sel_a, sel_b} != sel_exp) bad_sel++;
        if (!first && gap != 2*HALF) bad_gap++;
        first = 1'b0;
        gap = 0;
        if (sidx > 0) begin sidx--; sdi = slave[sidx]; end
      end else if (sclk && prev_s && (sdo != prev_d || sel_aux != prev_x)) begin
        bad_hold++;
      end
      prev_s = sclk; prev_d = sdo; prev_x = sel_aux;
      gap++;
      @(negedge clk);
    end
    // R2 / R3: clock count and bit order
    chk(rises == (dual ? 4 : 8), dual ? "R3" : "R2", "rising edges", rises, dual ? 4 : 8);
    chk(cap == tx, dual ? "R3" : "R2", "bits seen on the lines", cap, tx);
    // R4: spacing and hold while high
    chk(bad_gap == 0 && bad_hold == 0, "R4", "bit period faults", bad_gap + bad_hold, 0);
    // R5: select during shifting
    chk(bad_sel == 0, "R5", "select faults while shifting", bad_sel, 0);
    // R6: release or hold after the byte
    if (last) chk(sel_a && sel_b, "R6", "select after last byte", {sel_a, sel_b}, 3);
    else      chk({sel_a, sel_b} == sel_exp, "R6", "select held between bytes",
                  {sel_a, sel_b}, sel_exp);
    // R7 and R10: idle lines
    chk(sel_aux == 1'b1, "R7", "aux line idle", sel_aux, 1);
    chk(sclk == 1'b0, "R10", "sclk idle", sclk, 0);
    // R8 / R9: returned byte
    if (dual) chk(rx_valid == 1'b0, "R9", "rx_valid in two-bit mode", rx_valid, 0);
    else begin
      chk(rx_valid == rxen, "R8", "rx_valid", rx_valid, rxen);
      if (rxen) chk(rx_data == slave, "R8", "rx_data", rx_data, slave);
    end
    @(negedge clk);
    chk(rx_valid == 1'b0, "R8", "rx_valid one cycle", rx_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(in_ready == 1'b1, "R10", "in_ready at reset", in_ready, 1);
    chk(sclk == 1'b0, "R10", "sclk at reset", sclk, 0);
    chk({sel_a, sel_b, sel_aux} == 3'b111, "R10", "selects at reset",
        {sel_a, sel_b, sel_aux}, 7);
    chk(rx_valid == 1'b0, "R10", "rx_valid at reset", rx_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: busy right after accept is covered by xfer loop; check ready low here
    in_valid = 1'b1; in_data = 8'hA5; in_dual = 1'b0; in_dev = 2'd0;
    in_last = 1'b1; in_rx = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R1", "in_ready after accept", in_ready, 0);
    while (!in_ready) @(negedge clk);
    for (int mode = 0; mode < 2; mode++) begin
      for (int dev = 0; dev < 4; dev++) begin
        for (int b = 0; b < 256; b++) begin
          logic [7:0] tx, sl;
          tx = 8'(b);
          sl = 8'(b * 37 + dev * 11 + 8'h5A);
          xfer(tx, mode[0], 2'(dev), (b % 4) == 3, (b % 3) != 0, sl);
        end
      end
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule